// File: doc/BRIEF.md
# Two-Source Glitch-Free Clock Switchover

This block picks one of two free-running reference clocks, source A (`clk0_i`) or source B (`clk1_i`), and passes it to `clk_o`. Source A is in use after reset. A plain, asynchronous request line, `swreq_i`, asks for the other source. A request counts only when it is a fresh rising level that stays high long enough in both clock domains at once. Holding the line high after a switch has no further effect. The line has to drop before the next request can arm.

The handoff is break-before-make. The enable of the outgoing source drops on that source's falling edge. The enable of the incoming source rises on the incoming source's own falling edge, and only after it has seen the old enable go away through a two-flop synchronizer. `clk_o` therefore rests low between the last old pulse and the first new pulse, and it never carries a shortened high or low phase. `active_o` reports which source drives the output. It changes at the moment the new enable takes effect.

Each domain also watches the other clock for loss. If the peer clock stops, a flag for that clock rises, and the flag clears once the clock runs again. A request made while either clock is stopped does not switch. All pins are plain control and status levels. The block has no data stream, so it has no valid/ready handshake.

Top module: `clk_switch_ctrl`

## Requirements
- R1: After `rst_ni` is released, `active_o` is 0, both loss flags are 0, and `clk_o` follows `clk0_i`.
- R2: A request that stays high for at least six cycles of the slower input, with both inputs running, moves the output to the other source. `clk_o` then follows that source, and each later qualified request toggles back.
- R3: A request high for fewer than three cycles of the slower input causes no switch, even if that is three or more cycles of the faster input.
- R4: A request held high permanently causes exactly one switch. The request must return low before another switch can occur.
- R5: A request made while either input clock is stopped causes no switch, and the active source still drives `clk_o`.
- R6: While the input frequencies are within a factor of two of each other, a loss flag (`bad0_o` for source A, `bad1_o` for source B) stays 0 while its clock runs. The flag rises when its clock stops for more than four cycles of the other clock, and it clears after the clock resumes.
- R7: During a handoff the two source enables are never high together, `clk_o` shows no high or low phase shorter than 4 ns in the bench configuration, and a request that qualifies while a handoff is still in progress is discarded.
- R8: `active_o` encodes the source in use: 0 means `clk0_i`, 1 means `clk1_i`. It holds the old value until the new source's enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0_i | input | 1 | Reference clock source A |
| clk1_i | input | 1 | Reference clock source B |
| rst_ni | input | 1 | Asynchronous active-low reset |
| swreq_i | input | 1 | Asynchronous switch request level |
| clk_o | output | 1 | Gated, glitch-free selected clock |
| active_o | output | 1 | Source in use: 0 = A, 1 = B |
| bad0_o | output | 1 | Source A judged stopped |
| bad1_o | output | 1 | Source B judged stopped |

## Verification
A selection register that flips without a qualified request shows up as `active_o` changing, and `clk_o` follows the wrong source within about ten cycles of the slower clock. An enable that rises too early shows up as a short phase on `clk_o` in the same edge window as the handoff. A loss counter that does not reset on peer edges raises a false flag within a handful of cycles of the faster clock. Each of these is visible at the pins well before the next request in the bench.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

  localparam int unsigned NUM_SRC = 2;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_e;

  // While neither enable is up, the source still driving is the one
  // opposite the newly chosen selection.
  function automatic src_e pick_active(logic en_a, logic en_b, logic sel);
    if (en_a)      return SRC_A;
    else if (en_b) return SRC_B;
    else           return src_e'(~sel);
  endfunction

endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
  parameter int unsigned    W       = 1,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= RST_VAL;
          else         stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= RST_VAL;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/clksw_qual.sv
`timescale 1ns/1ps
module clksw_qual #(
  parameter int unsigned HOLD = 3,
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic held_o
);

  localparam int unsigned      CW     = $clog2(HOLD + 1);
  localparam logic [CW-1:0]    HOLD_V = CW'(HOLD);

  logic          req_s;
  logic [CW-1:0] cnt_q;

  clksw_sync #(.W(1), .STAGES(SYNC), .RST_VAL(1'b0)) u_req_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_i),
    .q_o    (req_s)
  );

  // Saturating run-length of the synchronized request; it only clears
  // when the request drops, so a held line cannot re-qualify.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!req_s)          cnt_q <= '0;
    else if (cnt_q != HOLD_V) cnt_q <= cnt_q + 1'b1;
  end

  assign held_o = (cnt_q == HOLD_V);

  // R3: qualification needs the request high in the preceding cycle.
  a_r3_held_follows_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_o |-> $past(req_s));

  // R3: the run-length never passes its target.
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= HOLD_V);

endmodule

// File: rtl/clksw_loss.sv
`timescale 1ns/1ps
module clksw_loss #(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned DIV   = 2,
  parameter int unsigned SYNC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic peer_tgl_i,
  output logic own_tgl_o,
  output logic peer_bad_o
);

  localparam int unsigned   DW     = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
  localparam int unsigned   CW     = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
  localparam logic [CW-1:0] SAT_V  = CW'(LIMIT + 1);

  logic [DW-1:0] div_q;
  logic          tgl_q;
  logic          peer_s;
  logic          peer_prev_q;
  logic          peer_edge;
  logic [CW-1:0] gap_q;
  logic          bad_q;

  // Divided heartbeat so a slower peer (within 2x) never aliases it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      tgl_q <= 1'b0;
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      tgl_q <= ~tgl_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign own_tgl_o = tgl_q;

  clksw_sync #(.W(1), .STAGES(SYNC), .RST_VAL(1'b0)) u_peer_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (peer_tgl_i),
    .q_o    (peer_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) peer_prev_q <= 1'b0;
    else         peer_prev_q <= peer_s;
  end

  assign peer_edge = peer_s ^ peer_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      bad_q <= 1'b0;
    end else if (peer_edge) begin
      gap_q <= '0;
      bad_q <= 1'b0;
    end else begin
      if (gap_q != SAT_V) gap_q <= gap_q + 1'b1;
      if (gap_q >= LIM_V) bad_q <= 1'b1;
    end
  end

  assign peer_bad_o = bad_q;

  // R6: any observed peer activity clears the flag in the next cycle.
  a_r6_clear_on_activity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peer_edge |=> !peer_bad_o);

  // R6: the silence counter stays within its saturation value.
  a_r6_gap_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= SAT_V);

endmodule

// File: rtl/clksw_gate.sv
`timescale 1ns/1ps
module clksw_gate #(
  parameter int unsigned IDX  = 0,
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic peer_en_i,
  output logic en_o
);

  localparam logic MY_SEL  = 1'(IDX);
  localparam logic EN_RST  = (IDX == 0);
  // The peer of source A resets disabled, so A sees "peer off" at reset.
  localparam logic OFF_RST = (IDX == 0);

  logic [1:0] s_q;
  logic       sel_s;
  logic       peer_off_s;
  logic       en_q;

  clksw_sync #(.W(2), .STAGES(SYNC), .RST_VAL({1'b0, OFF_RST})) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sel_i, ~peer_en_i}),
    .q_o    (s_q)
  );

  assign sel_s      = s_q[1];
  assign peer_off_s = s_q[0];

  // Updated on the falling edge: the local clock is low, so the gated
  // output cannot be cut short or started mid-phase.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= EN_RST;
    else         en_q <= (sel_s == MY_SEL) && peer_off_s;
  end

  assign en_o = en_q;

  // R7: an enable only comes up once this domain has seen the peer off.
  a_r7_make_after_break: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> $past(peer_off_s));

endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
module clksw_ctrl #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic held_i,
  input  logic peer_held_i,
  input  logic own_bad_i,
  input  logic peer_bad_i,
  input  logic own_en_i,
  input  logic peer_en_i,
  output logic sel_o
);

  logic [2:0] x_q;
  logic       peer_held_s;
  logic       own_bad_s;
  logic       peer_en_s;
  logic       busy;
  logic       both_held;
  logic       clocks_ok;
  logic       armed_q;
  logic       sel_q;

  clksw_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b000)) u_xdom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({peer_held_i, own_bad_i, peer_en_i}),
    .q_o    (x_q)
  );

  assign peer_held_s = x_q[2];
  assign own_bad_s   = x_q[1];
  assign peer_en_s   = x_q[0];

  // Handoff settled means exactly the chosen side is enabled.
  assign busy      = sel_q ? !(peer_en_s && !own_en_i) : !(own_en_i && !peer_en_s);
  assign both_held = held_i && peer_held_s;
  assign clocks_ok = !own_bad_s && !peer_bad_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      sel_q   <= 1'b0;
    end else if (!held_i && !peer_held_s) begin
      armed_q <= 1'b1;
    end else if (armed_q && both_held) begin
      armed_q <= 1'b0;
      if (!busy && clocks_ok) sel_q <= ~sel_q;
    end
  end

  assign sel_o = sel_q;

  // R4: a selection change consumes an armed request.
  a_r4_switch_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != $past(sel_o)) |-> $past(armed_q));

  // R5: no change while either clock was flagged as lost.
  a_r5_no_switch_on_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != $past(sel_o)) |-> $past(clocks_ok));

  // R7: the selection is frozen while a handoff is in flight.
  a_r7_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy) |-> $stable(sel_o));

endmodule

// File: rtl/clk_switch_ctrl.sv
`timescale 1ns/1ps
module clk_switch_ctrl
  import clksw_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 3,
  parameter int unsigned LOSS_LIMIT  = 4,
  parameter int unsigned MON_DIV     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk0_i,
  input  logic clk1_i,
  input  logic rst_ni,
  input  logic swreq_i,
  output logic clk_o,
  output logic active_o,
  output logic bad0_o,
  output logic bad1_o
);

  logic [NUM_SRC-1:0] dom_clk;
  logic [NUM_SRC-1:0] held;
  logic [NUM_SRC-1:0] tgl;
  logic [NUM_SRC-1:0] peer_bad;
  logic [NUM_SRC-1:0] en;
  logic               sel;

  assign dom_clk = {clk1_i, clk0_i};

  genvar k;
  generate
    for (k = 0; k < NUM_SRC; k++) begin : g_dom
      clksw_qual #(.HOLD(HOLD_CYCLES), .SYNC(SYNC_STAGES)) u_qual (
        .clk_i  (dom_clk[k]),
        .rst_ni (rst_ni),
        .req_i  (swreq_i),
        .held_o (held[k])
      );

      clksw_loss #(.LIMIT(LOSS_LIMIT), .DIV(MON_DIV), .SYNC(SYNC_STAGES)) u_loss (
        .clk_i      (dom_clk[k]),
        .rst_ni     (rst_ni),
        .peer_tgl_i (tgl[1-k]),
        .own_tgl_o  (tgl[k]),
        .peer_bad_o (peer_bad[k])
      );

      clksw_gate #(.IDX(k), .SYNC(SYNC_STAGES)) u_gate (
        .clk_i     (dom_clk[k]),
        .rst_ni    (rst_ni),
        .sel_i     (sel),
        .peer_en_i (en[1-k]),
        .en_o      (en[k])
      );
    end
  endgenerate

  // Decisions live in the source A domain; source B facts are synchronized in.
  clksw_ctrl #(.SYNC(SYNC_STAGES)) u_ctrl (
    .clk_i       (clk0_i),
    .rst_ni      (rst_ni),
    .held_i      (held[0]),
    .peer_held_i (held[1]),
    .own_bad_i   (peer_bad[1]),
    .peer_bad_i  (peer_bad[0]),
    .own_en_i    (en[0]),
    .peer_en_i   (en[1]),
    .sel_o       (sel)
  );

  assign clk_o    = |(dom_clk & en);
  assign active_o = pick_active(en[0], en[1], sel);
  assign bad0_o   = peer_bad[1];
  assign bad1_o   = peer_bad[0];

  // R7: break-before-make across the two domains.
  always_comb begin
    if (rst_ni) begin
      a_r7_one_enable: assert (!(en[0] && en[1]))
        else $error("both source enables high");
    end
  end

endmodule

// File: tb/tb_clk_switch_ctrl.sv
`timescale 1ns/1ps
module tb_clk_switch_ctrl;

  localparam int T0 = 10;
  localparam int T1 = 18;
  localparam int WD_NS = 100000 * T0;

  logic clk0 = 1'b0;
  logic clk1 = 1'b0;
  logic rst_n = 1'b1;
  logic swreq = 1'b0;
  bit   run0 = 1'b1;
  bit   run1 = 1'b1;

  logic clk_o, active_o, bad0_o, bad1_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Stop a clock only while it is low.
  always #(T0/2) if (run0 || clk0) clk0 = ~clk0;
  always #(T1/2) if (run1 || clk1) clk1 = ~clk1;

  clk_switch_ctrl dut (
    .clk0_i   (clk0),
    .clk1_i   (clk1),
    .rst_ni   (rst_n),
    .swreq_i  (swreq),
    .clk_o    (clk_o),
    .active_o (active_o),
    .bad0_o   (bad0_o),
    .bad1_o   (bad1_o)
  );

  // Phase-width monitor on the output for R7.
  realtime t_rise = 0.0;
  realtime t_fall = 0.0;
  int      runts = 0;
  bit      mon = 1'b0;

  always @(posedge clk_o) begin
    if (mon && ($realtime - t_fall) < 4.0) runts++;
    t_rise = $realtime;
  end
  always @(negedge clk_o) begin
    if (mon && ($realtime - t_rise) < 4.0) runts++;
    t_fall = $realtime;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic follow(input logic src, input string tag);
    int miss = 0;
    for (int i = 0; i < 4; i++) begin
      if (src == 1'b0) begin
        @(posedge clk0); #1; if (clk_o !== 1'b1) miss++;
        @(negedge clk0); #1; if (clk_o !== 1'b0) miss++;
      end else begin
        @(posedge clk1); #1; if (clk_o !== 1'b1) miss++;
        @(negedge clk1); #1; if (clk_o !== 1'b0) miss++;
      end
    end
    check(miss == 0, tag, miss, 0);
  endtask

  task automatic pulse(input int width_ns);
    swreq = 1'b1;
    #(width_ns);
    swreq = 1'b0;
    #(40 * T1);
  endtask

  initial begin
    #(WD_NS);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int widths [8] = '{10, 20, 30, 150, 30, 180, 220, 20};
    logic exp_act;

    #1 rst_n = 1'b0;
    #(3 * T1 + 2) rst_n = 1'b1;
    #(20 * T1);
    mon = 1'b1;

    // R1 / R8: reset state and encoding
    check(active_o === 1'b0, "R1 active after reset", active_o, 0);
    check(bad0_o === 1'b0 && bad1_o === 1'b0, "R1 flags after reset", {bad1_o, bad0_o}, 0);
    follow(1'b0, "R1 clk_o follows source A");
    exp_act = 1'b0;

    // R2 / R3: sweep of request widths; accept only clearly long pulses
    for (int i = 0; i < 8; i++) begin
      pulse(widths[i]);
      if (widths[i] >= 6 * T1) begin
        exp_act = ~exp_act;
        check(active_o === exp_act, "R2 qualified request toggles", active_o, exp_act);
      end else begin
        check(active_o === exp_act, "R3 short request ignored", active_o, exp_act);
      end
      follow(exp_act, "R8 clk_o matches active_o");
    end
    check(bad0_o === 1'b0 && bad1_o === 1'b0, "R6 no false loss flag", {bad1_o, bad0_o}, 0);

    // R4: permanent high switches once, re-arm after low
    swreq = 1'b1;
    #(60 * T1);
    exp_act = ~exp_act;
    check(active_o === exp_act, "R4 held request switches once", active_o, exp_act);
    #(60 * T1);
    check(active_o === exp_act, "R4 held request no second switch", active_o, exp_act);
    follow(exp_act, "R4 clk_o while request held");
    swreq = 1'b0;
    #(40 * T1);
    pulse(220);
    exp_act = ~exp_act;
    check(active_o === exp_act, "R4 re-armed after low", active_o, exp_act);
    pulse(220);
    exp_act = ~exp_act;
    check(active_o === exp_act, "R2 toggle back to source A", active_o, exp_act);

    // R5 / R6: source B stopped
    run1 = 1'b0;
    #(40 * T0);
    check(bad1_o === 1'b1, "R6 bad1 raised on stop", bad1_o, 1);
    check(bad0_o === 1'b0, "R6 bad0 stays low", bad0_o, 0);
    pulse(220);
    check(active_o === 1'b0, "R5 no switch with B stopped", active_o, 0);
    follow(1'b0, "R5 source A still drives");
    run1 = 1'b1;
    #(20 * T1);
    check(bad1_o === 1'b0, "R6 bad1 clears on resume", bad1_o, 0);

    // R5 / R6: source A stopped
    run0 = 1'b0;
    #(20 * T1);
    check(bad0_o === 1'b1, "R6 bad0 raised on stop", bad0_o, 1);
    pulse(220);
    run0 = 1'b1;
    #(20 * T1);
    check(bad0_o === 1'b0, "R6 bad0 clears on resume", bad0_o, 0);
    check(active_o === 1'b0, "R5 no switch with A stopped", active_o, 0);
    follow(1'b0, "R5 source A after restart");

    // R2: normal operation resumes
    pulse(220);
    check(active_o === 1'b1, "R2 switch after recovery", active_o, 1);
    follow(1'b1, "R2 clk_o follows source B");

    // R7: no shortened phase anywhere on the output
    check(runts == 0, "R7 no runt phase on clk_o", runts, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule